// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Out

This block sits in front of the second ALU operand and reshapes a data word before the arithmetic or logic step uses it. In one pass it can shift the word left or right by any amount from 0 to one less than the word width. Right shifts can fill with zeros or with copies of the sign bit. It can also rotate the word right. A separate one-bit rotate mode treats the incoming carry flag as a 33rd bit, so the old carry enters the top bit and the lowest bit leaves as the new carry.

Along with the shifted word, the block produces the carry-out that the flag logic would latch. For any non-zero shift, this is the last bit pushed out of the operand. A zero-amount shift passes the incoming carry through. The result and the carry are registered, so they appear one clock after the inputs are sampled. A typical use is scaling an index by a power of two before it is added to a base, for example shifting a value left by 2 to turn a word index into a byte offset. The word width must be a power of two.

Top module: `operand_shifter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_out` and `c_out` become all zeros.
- R2: Each result and carry appear on the outputs at the first rising edge after the inputs that produced them are sampled, which is one cycle of latency.
- R3: With `kind_in` = 2'b00 (logical left), `ext_in` = 0 and amount n > 0, the result is the operand shifted left by n with zeros entering at bit 0, and `c_out` is operand bit W-n.
- R4: With `kind_in` = 2'b01 (logical right), `ext_in` = 0 and n > 0, zeros enter from bit W-1, and `c_out` is operand bit n-1.
- R5: With `kind_in` = 2'b10 (arithmetic right), `ext_in` = 0 and n > 0, copies of the original top bit enter from bit W-1, and `c_out` is operand bit n-1.
- R6: With `kind_in` = 2'b11 (rotate right), `ext_in` = 0 and n > 0, operand bit n-1 lands in bit W-1, no bit is lost, and `c_out` equals the new bit W-1.
- R7: With `ext_in` = 0 and amount 0, the result equals the operand for every `kind_in`, and `c_out` equals `c_in`.
- R8: With `ext_in` = 1, the result is `c_in` followed by operand bits W-1..1, and `c_out` is operand bit 0. `kind_in` and `amt_in` have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | W | Operand to be shifted |
| kind_in | input | 2 | Shift type: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_in | input | log2(W) | Shift amount, 0 to W-1 |
| ext_in | input | 1 | Selects the one-bit rotate through carry |
| c_in | input | 1 | Current carry flag |
| res_out | output | W | Registered shifted operand |
| c_out | output | 1 | Registered carry-out for the flag logic |

## Verification
The assertions assume that every input carries a defined 0 or 1 value whenever reset is low. They also assume that the inputs change only between rising edges, so the value recalled one edge back is exactly the value the registers captured. The stimulus meets both conditions. It sets every input to a known value at time zero and drives new values only on falling edges. Each result is read on the following falling edge, after the one register stage has loaded it.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_kind_e;
endpackage

// File: rtl/bshift_core.sv
// Logarithmic shifter: stage k moves the word by 2**k when amount bit k is set.
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  sh_kind_e      kind_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [AW:0][W-1:0] lvl;
  logic               sign_b;

  assign sign_b = data_i[W-1];
  assign lvl[0] = data_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      unique case (kind_i)
        SH_LSL:  moved = {lvl[k][W-1-S:0], {S{1'b0}}};
        SH_LSR:  moved = {{S{1'b0}}, lvl[k][W-1:S]};
        SH_ASR:  moved = {{S{sign_b}}, lvl[k][W-1:S]};
        default: moved = {lvl[k][S-1:0], lvl[k][W-1:S]};
      endcase
    end
    assign lvl[k+1] = amt_i[k] ? moved : lvl[k];
  end

  assign data_o = lvl[AW];
endmodule

// File: rtl/bshift_carry.sv
// Picks the last bit pushed out of the operand; W must be a power of two.
module bshift_carry
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  sh_kind_e      kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          ext_i,
  input  logic          c_i,
  output logic          c_o
);
  logic [AW-1:0] left_idx;
  logic [AW-1:0] right_idx;

  // W - n modulo W equals 0 - n in AW bits
  assign left_idx  = '0 - amt_i;
  assign right_idx = amt_i - 1'b1;

  always_comb begin
    if (ext_i)
      c_o = data_i[0];
    else if (amt_i == '0)
      c_o = c_i;
    else if (kind_i == SH_LSL)
      c_o = data_i[left_idx];
    else
      c_o = data_i[right_idx];
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import bshift_pkg::*;
#(
  parameter  int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  op_in,
  input  logic [1:0]    kind_in,
  input  logic [AW-1:0] amt_in,
  input  logic          ext_in,
  input  logic          c_in,
  output logic [W-1:0]  res_out,
  output logic          c_out
);
  sh_kind_e     kind;
  logic [W-1:0] core_res;
  logic [W-1:0] next_res;
  logic         next_c;

  assign kind = sh_kind_e'(kind_in);

  bshift_core #(.W(W), .AW(AW)) u_core (
    .data_i (op_in),
    .kind_i (kind),
    .amt_i  (amt_in),
    .data_o (core_res)
  );

  bshift_carry #(.W(W), .AW(AW)) u_carry (
    .data_i (op_in),
    .kind_i (kind),
    .amt_i  (amt_in),
    .ext_i  (ext_in),
    .c_i    (c_in),
    .c_o    (next_c)
  );

  // 33-bit rotate by one: carry enters at the top
  assign next_res = ext_in ? {c_in, op_in[W-1:1]} : core_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
      c_out   <= 1'b0;
    end else begin
      res_out <= next_res;
      c_out   <= next_c;
    end
  end
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
  parameter  int W  = 32,
  localparam int AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  op_in,
  input logic [1:0]    kind_in,
  input logic [AW-1:0] amt_in,
  input logic          ext_in,
  input logic          c_in,
  input logic [W-1:0]  res_out,
  input logic          c_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_out == '0 && c_out == 1'b0));

  // R7
  zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_in && amt_in == '0) |=> (res_out == $past(op_in) && c_out == $past(c_in)));

  // R8
  rrx_chk: assert property (@(posedge clk) disable iff (rst)
    ext_in |=> (res_out == {$past(c_in), $past(op_in[W-1:1])} && c_out == $past(op_in[0])));

  // R6
  ror_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_in && kind_in == 2'b11 && amt_in != '0) |=> (c_out == res_out[W-1]));

  // R3
  lsl_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_in && kind_in == 2'b00 && amt_in != '0) |=> (res_out[0] == 1'b0));

  // R4
  lsr_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_in && kind_in == 2'b01 && amt_in != '0) |=> (res_out[W-1] == 1'b0));

  // R5
  asr_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_in && kind_in == 2'b10) |=> (res_out[W-1] == $past(op_in[W-1])));
endmodule

bind operand_shifter bshift_chk #(.W(W)) u_chk (.*);

// File: tb/operand_shifter_bench.sv
`timescale 1ns/1ps
module operand_shifter_bench;
  localparam int W  = 32;
  localparam int AW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  op_in = '0;
  logic [1:0]    kind_in = 2'b00;
  logic [AW-1:0] amt_in = '0;
  logic          ext_in = 1'b0;
  logic          c_in = 1'b0;
  logic [W-1:0]  res_out;
  logic          c_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  operand_shifter #(.W(W)) u_operand_shifter (.*);

  // Expected {carry, result} built from the requirement text
  function automatic logic [W:0] expect_val(logic [W-1:0] op, logic [1:0] kind,
                                            int n, logic ext, logic cin);
    logic [W-1:0] r;
    logic         c;
    if (ext) return {op[0], cin, op[W-1:1]};
    if (n == 0) return {cin, op};
    for (int b = 0; b < W; b++) begin
      case (kind)
        2'b00:   r[b] = (b >= n) ? op[b-n] : 1'b0;
        2'b01:   r[b] = (b + n < W) ? op[b+n] : 1'b0;
        2'b10:   r[b] = (b + n < W) ? op[b+n] : op[W-1];
        default: r[b] = op[(b + n) % W];
      endcase
    end
    c = (kind == 2'b00) ? op[W-n] : op[n-1];
    return {c, r};
  endfunction

  task automatic apply_check(logic [W-1:0] op, logic [1:0] kind, int n,
                             logic ext, logic cin, string req);
    logic [W:0] exp;
    @(negedge clk);
    op_in = op; kind_in = kind; amt_in = AW'(n); ext_in = ext; c_in = cin;
    exp = expect_val(op, kind, n, ext, cin);
    @(negedge clk);
    checks++;
    if ({c_out, res_out} !== exp) begin
      fails++;
      $display("FAIL %s: op=%h kind=%0d n=%0d ext=%0b cin=%0b got c=%0b r=%h exp c=%0b r=%h",
               req, op, kind, n, ext, cin, c_out, res_out, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; op_in = 32'hFFFF_FFFF; ext_in = 1'b1; c_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (res_out !== '0 || c_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: got c=%0b r=%h exp c=0 r=0", c_out, res_out);
    end
    rst = 1'b0; ext_in = 1'b0;
  endtask

  task automatic t_lsl();
    apply_check(32'h0000_0007, 2'b00, 2, 1'b0, 1'b0, "R3");
    apply_check(32'h8000_0001, 2'b00, 1, 1'b0, 1'b0, "R3");
    apply_check(32'h0000_0001, 2'b00, 31, 1'b0, 1'b1, "R3");
    apply_check(32'h1234_5678, 2'b00, 4, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_lsr();
    apply_check(32'h8000_0001, 2'b01, 1, 1'b0, 1'b0, "R4");
    apply_check(32'hFFFF_FFFF, 2'b01, 31, 1'b0, 1'b0, "R4");
    apply_check(32'h0000_0100, 2'b01, 9, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_asr();
    apply_check(32'h8000_0000, 2'b10, 31, 1'b0, 1'b0, "R5");
    apply_check(32'hF000_000F, 2'b10, 4, 1'b0, 1'b0, "R5");
    apply_check(32'h7000_0010, 2'b10, 5, 1'b0, 1'b1, "R5");
  endtask

  task automatic t_ror();
    apply_check(32'h0000_0001, 2'b11, 1, 1'b0, 1'b0, "R6");
    apply_check(32'h0000_00F0, 2'b11, 8, 1'b0, 1'b0, "R6");
    apply_check(32'hDEAD_BEEF, 2'b11, 31, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_zero();
    for (int k = 0; k < 4; k++) begin
      apply_check(32'hA5A5_0F0F, 2'(k), 0, 1'b0, 1'b1, "R7");
      apply_check(32'h5A5A_F0F0, 2'(k), 0, 1'b0, 1'b0, "R7");
    end
  endtask

  task automatic t_rrx();
    apply_check(32'h0000_0001, 2'b00, 0, 1'b1, 1'b1, "R8");
    apply_check(32'hFFFF_FFFE, 2'b01, 17, 1'b1, 1'b0, "R8");
    apply_check(32'h8000_0003, 2'b10, 31, 1'b1, 1'b1, "R8");
    apply_check(32'h1234_5679, 2'b11, 5, 1'b1, 1'b0, "R8");
  endtask

  // Back-to-back inputs: each cycle's output must match the previous cycle's inputs
  task automatic t_latency();
    logic [W:0] exp;
    @(negedge clk);
    op_in = 32'hC000_0003; kind_in = 2'b00; amt_in = AW'(1); ext_in = 1'b0; c_in = 1'b0;
    @(negedge clk);
    exp = expect_val(32'hC000_0003, 2'b00, 1, 1'b0, 1'b0);
    op_in = 32'h0000_0003; kind_in = 2'b11;
    checks++;
    if ({c_out, res_out} !== exp) begin
      fails++;
      $display("FAIL R2: got c=%0b r=%h exp c=%0b r=%h", c_out, res_out, exp[W], exp[W-1:0]);
    end
    @(negedge clk);
    exp = expect_val(32'h0000_0003, 2'b11, 1, 1'b0, 1'b0);
    checks++;
    if ({c_out, res_out} !== exp) begin
      fails++;
      $display("FAIL R2: got c=%0b r=%h exp c=%0b r=%h", c_out, res_out, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 4; k++)
      for (int n = 1; n < W; n++)
        apply_check(32'h9E37_79B9 ^ (32'h1 << n), 2'(k), n, 1'b0, n[0],
                    (k == 0) ? "R3" : (k == 1) ? "R4" : (k == 2) ? "R5" : "R6");
  endtask

  initial begin
    t_reset();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_zero();
    t_rrx();
    t_latency();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule